// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 512K words by 8 bits. The host presents a request with a read/write flag, a 19-bit address and write data, and holds it until a one-cycle acknowledge comes back. For reads, the returned byte is valid in the same cycle as that acknowledge. On the memory side the block drives the address, active-low chip select, write enable and output enable. It also drives a split data bus: output value, driver enable and input value.

Every strobe phase length is a parameter counted in clock cycles. Each length is derived from a nanosecond limit and the clock period: the ceiling of limit divided by period, and never less than one cycle. Writes end on the rising edge of write enable while chip select stays low. After every read the controller holds its data drivers off until the memory has had time to release the shared pins. The address space is flat. The upper address bits, which pick one of four internal banks of the memory, pass through unchanged.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, chip select, write enable and output enable are high (inactive) and the data driver enable is low. The acknowledge output is also low.
- R2: Write enable is low only while chip select is low and output enable is high. A write ends when write enable rises while chip select is still low.
- R3: In a write, chip select goes low one cycle after the request is accepted, with the data drivers on from that cycle. Write enable follows the setup phase (1 cycle by default) and stays low for the pulse phase: the largest of the pulse width, the address-setup-to-end time minus setup, and the data setup, which is 16 cycles by default. After that comes the hold phase (1 cycle by default) with write enable high, chip select low and data still driven.
- R4: In a read, chip select and output enable go low one cycle after acceptance, with write enable high. They stay low for the largest of the address access time, the output-enable access time and the read cycle time, which is 18 cycles by default. The input bus is sampled at the clock edge that ends this window.
- R5: The acknowledge is high for exactly one cycle per transaction. For a read, the read-data output in that cycle equals the input bus value sampled at the end of the read window.
- R6: After a read, chip select and output enable stay high, with the data drivers off, for the turnaround count (7 cycles by default) before the controller returns to idle. Data is never driven until output enable has been high for at least that many cycles.
- R7: The data driver enable is never high while output enable is low.
- R8: Address, write data and the read/write flag are registered when a request is accepted. Changes on those host inputs before the acknowledge do not affect the memory-side address or write data.
- R9: Chip select returns high for at least one cycle between transactions. Every chip-select-low period lasts at least the smaller of the read and write cycle times in cycles (18 by default).
- R10: The full 19-bit address appears unchanged on the memory address pins, including the two top bits that select a bank inside the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with the acknowledge |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the shared data pins |
| mem_dq_oe | output | 1 | Driver enable for the data pins |
| mem_dq_in | input | 8 | Value read from the shared data pins |

## Verification
The controller is driven with isolated writes and reads, read-after-write to the same word, writes spread over all four bank-select values, a read of a never-written word, and back-to-back reads followed straight away by a write. The bank spread tells a correct flat address path from one that drops or remaps the top bits. Read-then-write exposes a missing or short bus turnaround. The device model in the bench puts valid data on the bus only once the full access window has elapsed, so a controller that samples early returns a wrong byte. During every transaction the host inputs are scrambled after acceptance, which separates registered request fields from a path that feeds the inputs straight through.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WGAP,
        ST_RACC,
        ST_RTURN
    } asram_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } asram_pins_t;

    // cycles covering a nanosecond limit, never fewer than one
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= len - CNT_W'(1);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign done = (remain == '0);
endmodule

// File: rtl/asram_req_latch.sv
module asram_req_latch #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            data_o <= '0;
        end else if (capture) begin
            addr_o <= addr_i;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/asram_strobe_decode.sv
module asram_strobe_decode
    import asram_pkg::*;
(
    input  asram_state_e state,
    output asram_pins_t  pins
);
    always_comb begin
        pins = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        unique case (state)
            ST_WSETUP, ST_WHOLD: begin
                pins.cs_n  = 1'b0;
                pins.drive = 1'b1;
            end
            ST_WPULSE: begin
                pins.cs_n  = 1'b0;
                pins.we_n  = 1'b0;
                pins.drive = 1'b1;
            end
            ST_RACC: begin
                pins.cs_n = 1'b0;
                pins.oe_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 4,
    parameter int T_AA_NS   = 70,
    parameter int T_DOE_NS  = 35,
    parameter int T_RC_NS   = 70,
    parameter int T_WC_NS   = 70,
    parameter int T_PWE_NS  = 55,
    parameter int T_AW_NS   = 65,
    parameter int T_SA_NS   = 0,
    parameter int T_SD_NS   = 30,
    parameter int T_HD_NS   = 0,
    parameter int T_HZ_NS   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // phase lengths in cycles
    localparam int L_SETUP = ns_to_cyc(T_SA_NS, CLK_NS);
    localparam int L_PULSE = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS),
                                       ns_to_cyc(T_AW_NS, CLK_NS) - L_SETUP),
                                  ns_to_cyc(T_SD_NS, CLK_NS));
    localparam int L_WHOLD = imax(ns_to_cyc(T_HD_NS, CLK_NS),
                                  ns_to_cyc(T_WC_NS, CLK_NS) - L_SETUP - L_PULSE);
    localparam int L_GAP   = 1;
    localparam int L_RACC  = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                       ns_to_cyc(T_DOE_NS, CLK_NS)),
                                  ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int L_TURN  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int L_MINCS = imin(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS));
    localparam int L_MAX   = imax(imax(imax(L_SETUP, L_PULSE), imax(L_WHOLD, L_RACC)),
                                  imax(L_TURN, L_GAP));
    localparam int CNT_W   = $clog2(L_MAX + 1);

    asram_state_e     state, state_nxt;
    asram_pins_t      pins;
    logic             ph_done;
    logic             ph_load;
    logic [CNT_W-1:0] ph_len;
    logic             accept;
    logic             win_end;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign ph_load = (state_nxt != state);

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nxt = req_write ? ST_WSETUP : ST_RACC;
            ST_WSETUP: if (ph_done) state_nxt = ST_WPULSE;
            ST_WPULSE: if (ph_done) state_nxt = ST_WHOLD;
            ST_WHOLD:  if (ph_done) state_nxt = ST_WGAP;
            ST_WGAP:   if (ph_done) state_nxt = ST_IDLE;
            ST_RACC:   if (ph_done) state_nxt = ST_RTURN;
            ST_RTURN:  if (ph_done) state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // length of the phase being entered
    always_comb begin
        unique case (state_nxt)
            ST_WSETUP: ph_len = CNT_W'(L_SETUP);
            ST_WPULSE: ph_len = CNT_W'(L_PULSE);
            ST_WHOLD:  ph_len = CNT_W'(L_WHOLD);
            ST_RACC:   ph_len = CNT_W'(L_RACC);
            ST_RTURN:  ph_len = CNT_W'(L_TURN);
            default:   ph_len = CNT_W'(L_GAP);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (ph_load),
        .len  (ph_len),
        .done (ph_done)
    );

    asram_req_latch #(.AW(ADDR_W), .DW(DATA_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .addr_i  (req_addr),
        .data_i  (req_wdata),
        .addr_o  (mem_addr),
        .data_o  (mem_dq_out)
    );

    asram_strobe_decode u_dec (
        .state (state),
        .pins  (pins)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.drive;

    // completion: end of write hold or end of read window
    assign win_end = ph_done && ((state == ST_WHOLD) || (state == ST_RACC));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            req_ack <= win_end;
            if (ph_done && (state == ST_RACC)) rsp_rdata <= mem_dq_in;
        end
    end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int TURN_CYC   = 7,
    parameter int MIN_CS_CYC = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out
);
    logic [15:0] oe_hi_cnt;
    logic [15:0] cs_lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_hi_cnt <= 16'(TURN_CYC);
            cs_lo_cnt <= '0;
        end else begin
            if (!mem_oe_n)                 oe_hi_cnt <= '0;
            else if (oe_hi_cnt != 16'hFFFF) oe_hi_cnt <= oe_hi_cnt + 16'd1;
            if (mem_cs_n)                  cs_lo_cnt <= '0;
            else if (cs_lo_cnt != 16'hFFFF) cs_lo_cnt <= cs_lo_cnt + 16'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ack));

    p_we_gated_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    p_we_ends_write_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_cs_n);

    p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (oe_hi_cnt >= 16'(TURN_CYC)));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    p_wdata_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_cs_min_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> (cs_lo_cnt >= 16'(MIN_CS_CYC)));
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TURN_CYC   (L_TURN),
    .MIN_CS_CYC (L_MINCS)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ack    (req_ack),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;
    // default phase lengths at 4 ns: setup, pulse, hold, read window, turnaround
    localparam int WS = 1;
    localparam int WP = 16;
    localparam int WH = 1;
    localparam int RA = 18;
    localparam int RT = 7;
    localparam int WDOG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit running = 0;

    always #2 clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'h15};
    endfunction

    // reference model: host view and expected pin timeline
    typedef enum {M_IDLE, M_WR, M_RD} mmode_e;
    mmode_e      mmode = M_IDLE;
    int          mt = 0;
    logic [18:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    logic [7:0]  ref_mem [logic [18:0]];
    logic [7:0]  dev_mem [logic [18:0]];

    always @(posedge clk) begin
        if (rst) begin
            mmode = M_IDLE;
        end else begin
            case (mmode)
                M_IDLE: if (req_valid) begin
                    mmode  = req_write ? M_WR : M_RD;
                    mt     = 0;
                    m_addr = req_addr;
                    m_data = req_wdata;
                    if (req_write) ref_mem[req_addr] = req_wdata;
                end
                M_WR: begin mt++; if (mt > WS + WP + WH) mmode = M_IDLE; end
                M_RD: begin mt++; if (mt > RA + RT - 1) mmode = M_IDLE; end
                default: mmode = M_IDLE;
            endcase
        end
    end

    // per-cycle comparison and device model
    logic prev_we_n = 1'b1;
    int   rd_run = 0;

    always @(negedge clk) begin
        logic [4:0] exp_p;
        logic [4:0] act_p;
        logic [7:0] exp_rd;
        string      tag;
        if (running) begin
            tag = "R9";
            exp_p = 5'b11100; // cs_n we_n oe_n drive ack
            if (mmode == M_WR) begin
                tag = "R3";
                if (mt < WS)                exp_p = 5'b01110;
                else if (mt < WS + WP)      exp_p = 5'b00110;
                else if (mt < WS + WP + WH) exp_p = 5'b01110;
                else                        exp_p = 5'b11101;
            end else if (mmode == M_RD) begin
                if (mt < RA) begin tag = "R4"; exp_p = 5'b01000; end
                else begin tag = "R6"; exp_p = (mt == RA) ? 5'b11101 : 5'b11100; end
            end
            act_p = {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ack};
            chk(act_p === exp_p, tag, int'(act_p), int'(exp_p));
            if (!mem_oe_n) chk(mem_dq_oe === 1'b0, "R7", int'(mem_dq_oe), 0);
            if (!mem_we_n) chk(!mem_cs_n && mem_oe_n, "R2", int'({mem_cs_n, mem_oe_n}), 1);
            if (!mem_cs_n) chk(mem_addr === m_addr, "R8 R10 address", int'(mem_addr), int'(m_addr));
            if (mem_dq_oe) chk(mem_dq_out === m_data, "R8 write data", int'(mem_dq_out), int'(m_data));
            if (req_ack && mmode == M_RD) begin
                exp_rd = ref_mem.exists(m_addr) ? ref_mem[m_addr] : dflt(m_addr);
                chk(rsp_rdata === exp_rd, "R5 read data", int'(rsp_rdata), int'(exp_rd));
            end
            // device: capture on write-enable rise, drive data only after full access
            if (!prev_we_n && mem_we_n && !mem_cs_n) dev_mem[mem_addr] = mem_dq_out;
            prev_we_n = mem_we_n;
            if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_run++;
            else rd_run = 0;
            exp_rd = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : dflt(mem_addr);
            mem_dq_in = (rd_run >= RA) ? exp_rd : ~exp_rd;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            chk(1'b0, "R9 watchdog", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_op(input logic wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        while (mmode != M_IDLE) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        // scramble host inputs after acceptance (R8)
        req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        while (!req_ack) @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ack} === 5'b11100, "R1 reset",
            int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ack}), 5'b11100);
        rst = 1'b0;
        running = 1;
        repeat (2) @(negedge clk);
        do_op(1'b1, 19'h00012, 8'h3C);
        do_op(1'b0, 19'h00012, 8'h00);
        // all four bank-select values (R10)
        for (int b = 0; b < 4; b++) do_op(1'b1, {b[1:0], 17'h1A5C3}, 8'h90 + 8'(b));
        for (int b = 3; b >= 0; b--) do_op(1'b0, {b[1:0], 17'h1A5C3}, 8'h00);
        do_op(1'b0, 19'h7FFFF, 8'h00);
        // back-to-back reads then an immediate write (R6)
        do_op(1'b0, 19'h00012, 8'h00);
        do_op(1'b0, 19'h40000, 8'h00);
        do_op(1'b1, 19'h40000, 8'hE7);
        do_op(1'b0, 19'h40000, 8'h00);
        do_op(1'b1, 19'h00012, 8'h00);
        do_op(1'b0, 19'h00012, 8'hFF);
        repeat (30) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule